// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block keeps the registered word address of a synchronous burst memory and works out the internal address for every beat of a four-beat burst. A burst begins on any clock edge where one of two active-low address strobes is sampled low. One strobe comes from a processor and the other from a cache controller. On that edge the external address is captured and the beat index goes to zero.

After the first beat, the block makes later addresses itself from a beat counter. The counter moves on only when the advance input is high. Only the low bits of the address change; the upper bits keep the captured value.

A static order input chooses between two orderings of the low bits. Linear order counts up and wraps. Interleaved order XORs the starting low bits with the beat count. All inputs are sampled on the rising clock edge, and both outputs come straight from registers, so each result appears one clock after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` becomes 0 and `beat_idx` becomes 0 after that edge, whatever the other inputs are.
- R2: When `proc_strb_n` is sampled low, `cur_addr` equals the sampled `ext_addr` and `beat_idx` equals 0 after that edge.
- R3: When `cache_strb_n` is sampled low, `cur_addr` equals the sampled `ext_addr` and `beat_idx` equals 0 after that edge.
- R4: With `ilv_mode` = 0 (linear), each sampled advance sets `cur_addr[1:0]` to (start low bits + new beat index) mod 4. `cur_addr[16:2]` keeps the loaded value.
- R5: With `ilv_mode` = 1 (interleaved), each sampled advance sets `cur_addr[1:0]` to start low bits XOR new beat index. For example, start 2 gives 2, 3, 0, 1.
- R6: When both strobes are high and `adv` is low, `cur_addr` and `beat_idx` keep their values.
- R7: A strobe sampled low takes precedence over `adv`. It reloads `ext_addr` and sets `beat_idx` to 0 even when `adv` is high in the same cycle.
- R8: After four advances with no strobe, `beat_idx` is back at 0 and `cur_addr` is back at the burst's starting address, in both orders.
- R9: Each sampled advance with no strobe raises `beat_idx` by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 17 | External word address captured on a strobe |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| cache_strb_n | input | 1 | Cache-controller address strobe, active low |
| adv | input | 1 | Burst advance, active high |
| ilv_mode | input | 1 | Order select: 0 linear, 1 interleaved |
| cur_addr | output | 17 | Registered address of the current beat |
| beat_idx | output | 2 | Registered beat index, 0 to 3 |

## Verification
Any wrong internal state appears at the ports one clock after it forms, because both outputs are registers:
- A wrong stored start value shows as a wrong low address on the very next advance.
- A slipped beat counter shows at once on `beat_idx` and also misplaces the low address bits.
- A lost load or an overridden strobe shows one cycle after the strobe edge.

Wrap-around errors show only on the fifth beat, so a burst is walked through all four beats and one more in each order.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/bas_strobe_merge.sv
module bas_strobe_merge #(
  parameter int N_STRB = 2
) (
  input  logic [N_STRB-1:0] strb_n,
  output logic              load
);

  logic [N_STRB:0] acc;

  assign acc[0] = 1'b0;

  generate
    for (genvar i = 0; i < N_STRB; i++) begin : g_or
      assign acc[i+1] = acc[i] | ~strb_n[i];
    end
  endgenerate

  assign load = acc[N_STRB];

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);

  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + BEAT_W'(1);
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_out
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo = start_lo + beat;

  generate
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
      assign ilv_lo[b] = start_lo[b] ^ beat[b];
    end
  endgenerate

  always_comb begin
    unique case (order)
      ORD_LINEAR:     low_out = lin_lo;
      ORD_INTERLEAVE: low_out = ilv_lo;
      default:        low_out = ilv_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strb_n,
  input  logic              cache_strb_n,
  input  logic              adv,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] start_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [HI_W-1:0]   hi_q;
  logic [HI_W-1:0]   hi_nxt;
  order_e            order;

  assign order = order_e'(ilv_mode);

  bas_strobe_merge #(.N_STRB(2)) u_strb (
    .strb_n ({cache_strb_n, proc_strb_n}),
    .load   (load)
  );

  assign step = adv & ~load;

  bas_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .beat_q   (beat_idx),
    .beat_nxt (beat_nxt)
  );

  assign start_nxt = load ? ext_addr[BEAT_W-1:0] : start_q;
  assign hi_nxt    = load ? ext_addr[ADDR_W-1:BEAT_W] : hi_q;

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order    (order),
    .start_lo (start_nxt),
    .beat     (beat_nxt),
    .low_out  (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      hi_q     <= '0;
      cur_addr <= '0;
    end else begin
      start_q  <= start_nxt;
      hi_q     <= hi_nxt;
      if (load || step) cur_addr <= {hi_nxt, low_nxt};
    end
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              proc_strb_n,
  input logic              cache_strb_n,
  input logic              adv,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [BEAT_W-1:0] beat_idx
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cur_addr == '0) && (beat_idx == '0));

  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_strb_n |=> (cur_addr == $past(ext_addr)) && (beat_idx == '0));

  // R3
  cache_load_chk: assert property (@(posedge clk) disable iff (rst)
    !cache_strb_n |=> (cur_addr == $past(ext_addr)) && (beat_idx == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && cache_strb_n && !adv) |=> $stable(cur_addr) && $stable(beat_idx));

  // R9
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && cache_strb_n && adv) |=> beat_idx == BEAT_W'($past(beat_idx) + BEAT_W'(1)));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && cache_strb_n && adv) |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_addr     (ext_addr),
  .proc_strb_n  (proc_strb_n),
  .cache_strb_n (cache_strb_n),
  .adv          (adv),
  .cur_addr     (cur_addr),
  .beat_idx     (beat_idx)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

  localparam int AW = 17;
  localparam int BW = 2;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          proc_strb_n = 1'b1;
  logic          cache_strb_n = 1'b1;
  logic          adv = 1'b0;
  logic          ilv_mode = 1'b1;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] beat_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk          (clk),
    .rst          (rst),
    .ext_addr     (ext_addr),
    .proc_strb_n  (proc_strb_n),
    .cache_strb_n (cache_strb_n),
    .adv          (adv),
    .ilv_mode     (ilv_mode),
    .cur_addr     (cur_addr),
    .beat_idx     (beat_idx)
  );

  // vector: {proc_strb_n, cache_strb_n, adv, ilv_mode, ext_addr, exp_addr, exp_beat}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 17'h1A5F6, 17'h1A5F6, 2'd0}, // R2 load
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1A5F7, 2'd1}, // R4 R9
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1A5F4, 2'd2}, // R4
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1A5F5, 2'd3}, // R4
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1A5F6, 2'd0}, // R8 wrap linear
    {1'b1, 1'b1, 1'b0, 1'b0, 17'h0ABCD, 17'h1A5F6, 2'd0}, // R6 hold
    {1'b1, 1'b0, 1'b0, 1'b1, 17'h0C03E, 17'h0C03E, 2'd0}, // R3 load
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h0C03F, 2'd1}, // R5
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h0C03C, 2'd2}, // R5
    {1'b1, 1'b1, 1'b0, 1'b1, 17'h1FFFF, 17'h0C03C, 2'd2}, // R6 hold mid-burst
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h0C03D, 2'd3}, // R5
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h0C03E, 2'd0}, // R8 wrap interleaved
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h0C03F, 2'd1}, // R9
    {1'b0, 1'b1, 1'b1, 1'b1, 17'h00005, 17'h00005, 2'd0}, // R7 strobe beats adv
    {1'b1, 1'b1, 1'b1, 1'b1, 17'h00000, 17'h00004, 2'd1}, // R5 start 1
    {1'b0, 1'b0, 1'b1, 1'b0, 17'h1FFFF, 17'h1FFFF, 2'd0}, // R7 both strobes
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1FFFC, 2'd1}, // R4 upper fixed
    {1'b1, 1'b1, 1'b1, 1'b0, 17'h00000, 17'h1FFFD, 2'd2}  // R4
  };

  task automatic check(input string req, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
    n_chk++;
    if (cur_addr !== ea || beat_idx !== eb) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, cur_addr, beat_idx, ea, eb);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      proc_strb_n  = VEC[i][39];
      cache_strb_n = VEC[i][38];
      adv          = VEC[i][37];
      ilv_mode     = VEC[i][36];
      ext_addr     = VEC[i][35:19];
      @(negedge clk);
      check($sformatf("vec%0d R2-R9 group", i), VEC[i][18:2], VEC[i][1:0]);
    end

    // R1: reset in mid-burst with a strobe present still clears
    proc_strb_n = 1'b0;
    ext_addr    = 17'h15555;
    adv         = 1'b1;
    rst         = 1'b1;
    @(negedge clk);
    check("R1 mid-burst", '0, '0);

    // R2 after reset release
    rst = 1'b0;
    @(negedge clk);
    check("R2 reload", 17'h15555, 2'd0);

    // R6 long hold across many cycles with changing ext_addr
    proc_strb_n = 1'b1;
    adv         = 1'b0;
    for (int k = 0; k < 5; k++) begin
      ext_addr = AW'(k * 37);
      @(negedge clk);
    end
    check("R6 long hold", 17'h15555, 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule